// File: doc/BRIEF.md
# Reference Clock Input Selection Controller

This block decides which of four reference clock inputs a downstream clock multiplexer and loop should use, driven only by a 2-bit select code from external pins. The pins are filtered first: a new code takes effect only after it has been seen unchanged on a fixed number of consecutive sample-clock edges. Codes that pass through briefly while the pins move are therefore ignored.

A configuration bit switches the block between two views. With the bit clear, each code names one input. With the bit set, the four inputs act as two pairs, and two of the four codes have no meaning. When such an unused code is accepted, the block raises a flag and keeps the last valid selection. The block never picks another input by itself. If the chosen input, or any member of the chosen pair, reports an alarm, it raises a hold request for the loop instead.

Top module: `refclk_select_ctrl`

## Requirements
- R1: With `pair_mode_i` low, accepted code 00, 01, 10 and 11 selects input 1, 2, 3 and 4. `active_onehot_o` bit k (k = 0..3) then marks input k+1, and `active_idx_o` equals the code.
- R2: With `pair_mode_i` high, accepted code 00 selects inputs 1 and 3 together: `active_onehot_o` = 4'b0101 and `active_idx_o` = 0.
- R3: With `pair_mode_i` high, accepted code 01 selects inputs 2 and 4 together: `active_onehot_o` = 4'b1010 and `active_idx_o` = 1.
- R4: With `pair_mode_i` high, accepted code 10 or 11 raises `reserved_o` and leaves the selection at the last valid code. A last valid code of 10 or 11 taken in single mode maps to the pair through its low bit. `reserved_o` is low at all other times.
- R5: A select code is accepted only after `sel_raw_i` has held it on STABLE_CYCLES consecutive rising edges. The new selection appears after the last of those edges. A code held for fewer edges changes nothing.
- R6: `hold_req_o` is high exactly when an `alarm_i` bit of a currently selected input is high. An alarm never changes the selection.
- R7: `hold_req_o` falls in the same cycle that the alarm on the selected input clears. It also falls in the same cycle that a different, alarm-free selection becomes active.
- R8: While reset is applied, and until it is released, the selection is input 1 (pair 1/3 in pair mode), `reserved_o` is low and `hold_req_o` is low, whatever the alarms are.
- R9: `pair_sel_o` shows whether the pair view is in force and follows `pair_mode_i`.
- R10: `active_onehot_o` has exactly one bit set in single mode and exactly two bits set in pair mode. Bit `active_idx_o` of it is always set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_raw_i | input | 2 | Unfiltered select code from the pins |
| pair_mode_i | input | 1 | High: inputs grouped as pairs 1/3 and 2/4 |
| alarm_i | input | 4 | Alarm flag per input, bit k for input k+1 |
| active_onehot_o | output | 4 | Inputs currently selected, one bit per input |
| active_idx_o | output | 2 | Encoded selection (pair number in pair mode) |
| pair_sel_o | output | 1 | Pair view in force |
| reserved_o | output | 1 | Accepted code is unused in pair mode |
| hold_req_o | output | 1 | Selected input in alarm, loop must hold |

## Verification
The bench builds the block with STABLE_CYCLES = 5 and leaves the default of 8 for elaboration only. With this short window, random pin activity often settles long enough to be accepted, and it also often produces bursts of one to four edges that must be rejected. The exact boundary between four and five steady edges is also driven directly. Pair-mode flips between the two views let an accepted code of 10 or 11 become reserved. This exercises the path where the last valid selection is reused.

// File: rtl/refclk_sel_pkg.sv
package refclk_sel_pkg;
  localparam int unsigned NUM_INPUTS = 4;
  localparam int unsigned CODE_W     = $clog2(NUM_INPUTS);
  localparam int unsigned PAIR_SPAN  = NUM_INPUTS / 2;
  typedef logic [CODE_W-1:0]     sel_code_t;
  typedef logic [NUM_INPUTS-1:0] in_mask_t;
endpackage

// File: rtl/refclk_sel_filter.sv
module refclk_sel_filter
  import refclk_sel_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sel_code_t raw_i,
  output sel_code_t code_o
);
  localparam int unsigned CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(STABLE_CYCLES);

  sel_code_t        cand_q, cand_n, code_q, code_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cand_n = cand_q;
    cnt_n  = cnt_q;
    code_n = code_q;
    cnt_en = 1'b0;
    if (raw_i != cand_q) begin
      cand_n = raw_i;
      cnt_n  = CNT_W'(1);
      cnt_en = 1'b1;
    end else if (cnt_q < SAT) begin
      cnt_n  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
      if (cnt_q == SAT - CNT_W'(1)) code_n = cand_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= SAT;
      code_q <= '0;
    end else begin
      if (cnt_en) begin
        cand_q <= cand_n;
        cnt_q  <= cnt_n;
      end
      code_q <= code_n;
    end
  end

  assign code_o = code_q;

  // R5: an accepted code must be what the pins showed on the accepting edge
  p_accept_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> ($past(raw_i) == code_q));
endmodule

// File: rtl/refclk_sel_map.sv
module refclk_sel_map
  import refclk_sel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sel_code_t code_i,
  input  logic      pair_mode_i,
  output in_mask_t  onehot_o,
  output sel_code_t idx_o,
  output logic      reserved_o
);
  sel_code_t last_q, act;
  logic      valid;

  assign valid = !(pair_mode_i && code_i[CODE_W-1]);
  assign act   = valid ? code_i : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= act;
  end

  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_sel
    assign onehot_o[i] = pair_mode_i ? (1'(i % PAIR_SPAN) == act[0])
                                     : (act == CODE_W'(i));
  end

  assign idx_o      = pair_mode_i ? {1'b0, act[0]} : act;
  assign reserved_o = !valid;

  // R4: while a reserved code stays in force the selection does not move
  p_reserved_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reserved_o && $past(reserved_o) && $stable(pair_mode_i)) |-> $stable(act));
endmodule

// File: rtl/refclk_select_ctrl.sv
module refclk_select_ctrl
  import refclk_sel_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_raw_i,
  input  logic       pair_mode_i,
  input  logic [3:0] alarm_i,
  output logic [3:0] active_onehot_o,
  output logic [1:0] active_idx_o,
  output logic       pair_sel_o,
  output logic       reserved_o,
  output logic       hold_req_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  sel_code_t  filt_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  refclk_sel_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .raw_i  (sel_raw_i),
    .code_o (filt_code)
  );

  refclk_sel_map u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .code_i      (filt_code),
    .pair_mode_i (pair_mode_i),
    .onehot_o    (active_onehot_o),
    .idx_o       (active_idx_o),
    .reserved_o  (reserved_o)
  );

  assign pair_sel_o = pair_mode_i;
  assign hold_req_o = rst_n && ((alarm_i & active_onehot_o) != '0);

  // R10: number of selected inputs matches the view
  p_onehot_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones(active_onehot_o) == (pair_mode_i ? 2 : 1));
  // R10: encoded index points at a selected input
  p_idx_in_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    active_onehot_o[active_idx_o]);
  // R6: a hold request needs some alarm
  p_hold_alarm_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    hold_req_o |-> (alarm_i != '0));
endmodule

// File: tb/refclk_select_ctrl_test.sv
module refclk_select_ctrl_test;
  localparam int unsigned STB = 5;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] sel_raw;
  logic       pair_mode;
  logic [3:0] alarm;
  logic [3:0] onehot;
  logic [1:0] idx;
  logic       pair_sel, reserved, hold;

  int errs = 0;
  int checks = 0;

  logic [1:0] m_cand, m_acc, m_last;
  int         m_cnt;

  always #10 clk = ~clk;

  refclk_select_ctrl #(.STABLE_CYCLES(STB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_raw_i(sel_raw), .pair_mode_i(pair_mode),
    .alarm_i(alarm), .active_onehot_o(onehot), .active_idx_o(idx),
    .pair_sel_o(pair_sel), .reserved_o(reserved), .hold_req_o(hold)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_mask(logic m, logic [1:0] a);
    return m ? (a[0] ? 4'b1010 : 4'b0101) : (4'b0001 << a);
  endfunction

  task automatic model_reset();
    m_cand = 2'd0; m_acc = 2'd0; m_last = 2'd0; m_cnt = STB;
  endtask

  // one sample cycle: drive at negedge, check settled outputs, advance model
  task automatic step(logic [1:0] r, logic m, logic [3:0] al);
    logic [1:0] a;
    logic [3:0] em;
    @(negedge clk);
    sel_raw = r; pair_mode = m; alarm = al;
    #2;
    a  = (m && m_acc[1]) ? m_last : m_acc;
    em = exp_mask(m, a);
    chk(m ? (a[0] ? "R3 pair mask" : "R2 pair mask") : "R1 single mask", 32'(onehot), 32'(em));
    chk("R10 index", 32'(idx), m ? 32'(a[0]) : 32'(a));
    chk("R4 reserved", 32'(reserved), 32'(m && m_acc[1]));
    chk("R6 hold", 32'(hold), 32'((al & em) != 4'b0));
    chk("R9 pair view", 32'(pair_sel), 32'(m));
    m_last = a;
    if (r != m_cand) begin
      m_cand = r; m_cnt = 1;
    end else if (m_cnt < STB) begin
      if (m_cnt == STB - 1) m_acc = m_cand;
      m_cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [1:0] r;
    logic       m;
    logic [3:0] al;
    void'($urandom(32'd4242));
    rst_ni = 1'b0; sel_raw = 2'd3; pair_mode = 1'b0; alarm = 4'hF;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R8 reset mask", 32'(onehot), 32'h1);
    chk("R8 reset hold", 32'(hold), 32'h0);
    chk("R8 reset reserved", 32'(reserved), 32'h0);
    pair_mode = 1'b1; #1;
    chk("R8 reset pair mask", 32'(onehot), 32'h5);
    sel_raw = 2'd0; pair_mode = 1'b0; alarm = 4'h0;
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) step(2'd0, 1'b0, 4'h0);

    // R5 boundary: STB-1 steady edges rejected, STB accepted
    for (int k = 0; k < STB - 1; k++) step(2'd2, 1'b0, 4'h0);
    step(2'd0, 1'b0, 4'h0);
    chk("R5 short burst ignored", 32'(idx), 32'h0);
    for (int k = 0; k < STB; k++) step(2'd2, 1'b0, 4'h0);
    chk("R5 not before last edge", 32'(idx), 32'h0);
    step(2'd2, 1'b0, 4'h0);
    chk("R5 accepted after STB edges", 32'(idx), 32'h2);

    // R1 all single codes
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < STB + 1; k++) step(2'(c), 1'b0, 4'h0);
      chk("R1 code maps to input", 32'(onehot), 32'(4'b0001 << c));
    end

    // R4 reserved in pair mode keeps last valid (3 -> pair 2/4)
    step(2'd3, 1'b1, 4'h0);
    chk("R4 reserved flag", 32'(reserved), 32'h1);
    chk("R3 last valid maps to pair", 32'(onehot), 32'hA);
    for (int k = 0; k < STB + 1; k++) step(2'd0, 1'b1, 4'h0);
    chk("R2 pair 1/3", 32'(onehot), 32'h5);
    for (int k = 0; k < STB + 1; k++) step(2'd2, 1'b1, 4'h0);
    chk("R4 reserved keeps pair 1/3", 32'(onehot), 32'h5);
    chk("R4 reserved raised", 32'(reserved), 32'h1);

    // R6/R7 hold behaviour in single mode
    for (int k = 0; k < STB + 1; k++) step(2'd1, 1'b0, 4'h0);
    step(2'd1, 1'b0, 4'h2);
    chk("R6 hold on alarm", 32'(hold), 32'h1);
    chk("R6 selection kept", 32'(idx), 32'h1);
    step(2'd1, 1'b0, 4'h0);
    chk("R7 hold drops with alarm", 32'(hold), 32'h0);
    for (int k = 0; k < STB + 1; k++) step(2'd3, 1'b0, 4'h2);
    chk("R7 hold drops on clean switch", 32'(hold), 32'h0);
    step(2'd3, 1'b1, 4'h2);
    chk("R6 pair member alarm", 32'(hold), 32'h1);

    // random phase
    r = 2'd0; m = 1'b0; al = 4'h0;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(5) == 0) r = 2'($urandom_range(3));
      if ($urandom_range(60) == 0) m = ~m;
      if ($urandom_range(7) == 0) al = 4'($urandom_range(15));
      step(r, m, al);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule